// File: doc/BRIEF.md
# Interrupt Entry Stack-and-Vector Sequencer

This block runs the interrupt-service phase of an 8-bit processor with a 16-bit address space. When the phase flag is raised, it looks at the pending-request line. With no request pending, it ends the phase at once and hands control back to instruction fetch.

With a request pending, it saves the return context on a byte stack that grows upward. The context is the program counter and a 16-bit status word. It then clears the global interrupt enable and captures the entry number of the request. Next it reads a two-byte handler address, high byte first, from a vector table, loads that address into the program counter and ends the phase.

The stack pointer, program counter and status word live outside the block. The block reads their current values and drives increment, load and clear strobes for them. All memory accesses use a request held until a one-cycle bus-complete pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset, `mem_rd`, `mem_wr`, `sp_inc`, `pc_ld`, `ie_clr`, `phase_clr` and `fetch_set` are all low.
- R2: If `irq_pend` is low when the phase starts, `phase_clr` and `fetch_set` pulse together exactly two cycles after `phase_req` is first seen high. There is no memory access, and SP and PC are left unchanged.
- R3: Each saved byte is written at the stack pointer value taken before its increment. `sp_inc` pulses once per byte. `mem_wr`, `mem_addr` and `mem_wdata` stay steady until `mem_done`.
- R4: Exactly four bytes are written, in this order: PC[15:8] at SP0, PC[7:0] at SP0+1, status[15:8] at SP0+2 and status[7:0] at SP0+3. The stack pointer ends at SP0+4.
- R5: `ie_clr` pulses exactly once, and only after the fourth write has completed. The saved status bytes therefore still hold the enable bit as it was on entry.
- R6: The first vector read is at `vec_base + 2*entry`, modulo 2^16, and returns the handler's high byte. The second read is at that address plus one and returns the low byte.
- R7: The entry number is sampled from `irq_num` in the cycle after the last push completes. Changes to `irq_num` before or after that cycle do not affect the vector address.
- R8: `pc_ld` pulses once, with `pc_nxt` equal to {high byte, low byte}. `phase_clr` and `fetch_set` follow in the next cycle.
- R9: Each vector read holds `mem_rd` and `mem_addr` steady until `mem_done`, for any number of wait states.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_req | input | 1 | Interrupt-service phase flag |
| phase_clr | output | 1 | Clears the interrupt-service phase flag |
| fetch_set | output | 1 | Sets the fetch phase flag |
| irq_pend | input | 1 | An interrupt request is pending |
| irq_num | input | NW | Entry number of the pending request |
| vec_base | input | 16 | Vector table base address |
| sp_cur | input | 16 | Current stack pointer |
| sp_inc | output | 1 | Increment the stack pointer |
| pc_cur | input | 16 | Current program counter |
| pc_ld | output | 1 | Load the program counter from pc_nxt |
| pc_nxt | output | 16 | Assembled handler address |
| psw_cur | input | 16 | Current status word |
| ie_clr | output | 1 | Clear the global interrupt enable |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, valid with mem_done |
| mem_done | input | 1 | Bus-complete pulse |

## Verification
The bypass ending is due at a fixed point: the second sampling point after `phase_req` rises. The bench counts cycles and checks exactly that cycle. A pushed byte is due in the cycle in which `mem_done` answers its write, so a monitor pops the expected byte from a queue at that point, whatever the random wait count was. The load-to-finish distance is a fixed one cycle, and the bench compares the recorded cycle numbers. The final SP, PC and enable bit are checked one cycle after `fetch_set`, once the register models in the bench have taken the strobes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int CTX_N = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PUSH_SET,
        ST_PUSH_WR,
        ST_LATCH,
        ST_VEC,
        ST_RD_HI,
        ST_RD_LO,
        ST_LOAD,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic ld_push;
        logic latch;
        logic ld_vec;
        logic cap_hi;
        logic cap_lo;
    } dp_ctl_t;

    function automatic dp_ctl_t ctl_for(seq_state_e s);
        dp_ctl_t c;
        c         = '0;
        c.ld_push = (s == ST_PUSH_SET);
        c.latch   = (s == ST_LATCH);
        c.ld_vec  = (s == ST_VEC);
        c.cap_hi  = (s == ST_RD_HI);
        c.cap_lo  = (s == ST_RD_LO);
        return c;
    endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int NBYTES = CTX_N,
    localparam int IW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phase_req,
    input  logic          irq_pend,
    input  logic          mem_done,
    output dp_ctl_t       ctl,
    output logic [IW-1:0] push_idx,
    output logic          sp_inc,
    output logic          ie_clr,
    output logic          pc_ld,
    output logic          phase_clr,
    output logic          fetch_set,
    output logic          mem_rd,
    output logic          mem_wr
);

    seq_state_e    state;
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE:     if (phase_req) state <= ST_CHECK;
                ST_CHECK: begin
                    idx   <= '0;
                    state <= irq_pend ? ST_PUSH_SET : ST_FIN;
                end
                ST_PUSH_SET: state <= ST_PUSH_WR;
                ST_PUSH_WR: begin
                    if (mem_done) begin
                        if (idx == IW'(NBYTES - 1)) begin
                            state <= ST_LATCH;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_PUSH_SET;
                        end
                    end
                end
                ST_LATCH:    state <= ST_VEC;
                ST_VEC:      state <= ST_RD_HI;
                ST_RD_HI:    if (mem_done) state <= ST_RD_LO;
                ST_RD_LO:    if (mem_done) state <= ST_LOAD;
                ST_LOAD:     state <= ST_FIN;
                ST_FIN:      state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl       = ctl_for(state);
        push_idx  = idx;
        sp_inc    = (state == ST_PUSH_SET);
        mem_wr    = (state == ST_PUSH_WR);
        ie_clr    = (state == ST_LATCH);
        mem_rd    = (state == ST_RD_HI) || (state == ST_RD_LO);
        pc_ld     = (state == ST_LOAD);
        phase_clr = (state == ST_FIN);
        fetch_set = (state == ST_FIN);
    end

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
    import irq_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int NW = 8,
    parameter int NBYTES = CTX_N,
    localparam int AW = 2 * DW,
    localparam int IW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  dp_ctl_t       ctl,
    input  logic [IW-1:0] push_idx,
    input  logic [AW-1:0] sp_cur,
    input  logic [AW-1:0] pc_cur,
    input  logic [AW-1:0] psw_cur,
    input  logic [NW-1:0] irq_num,
    input  logic [AW-1:0] vec_base,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_nxt
);

    logic [AW-1:0] mar;
    logic [DW-1:0] mdr;
    logic [NW-1:0] entry;
    logic [DW-1:0] vec_hi, vec_lo;
    logic [DW-1:0] ctx [NBYTES];

    // save order: program counter high, low, then status high, low
    always_comb begin
        ctx[0] = pc_cur[AW-1:DW];
        ctx[1] = pc_cur[DW-1:0];
        ctx[2] = psw_cur[AW-1:DW];
        ctx[3] = psw_cur[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar    <= '0;
            mdr    <= '0;
            entry  <= '0;
            vec_hi <= '0;
            vec_lo <= '0;
        end else begin
            if (ctl.ld_push) begin
                mar <= sp_cur;
                mdr <= ctx[push_idx];
            end
            if (ctl.latch) entry <= irq_num;
            if (ctl.ld_vec) mar <= vec_base + (AW'(entry) << 1);
            if (ctl.cap_hi && mem_done) begin
                vec_hi <= mem_rdata;
                mar    <= mar + 1'b1;
            end
            if (ctl.cap_lo && mem_done) vec_lo <= mem_rdata;
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign pc_nxt    = {vec_hi, vec_lo};

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int NW = 8,
    localparam int AW = 2 * DW,
    localparam int IW = $clog2(CTX_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phase_req,
    output logic          phase_clr,
    output logic          fetch_set,
    input  logic          irq_pend,
    input  logic [NW-1:0] irq_num,
    input  logic [AW-1:0] vec_base,
    input  logic [AW-1:0] sp_cur,
    output logic          sp_inc,
    input  logic [AW-1:0] pc_cur,
    output logic          pc_ld,
    output logic [AW-1:0] pc_nxt,
    input  logic [AW-1:0] psw_cur,
    output logic          ie_clr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done
);

    dp_ctl_t       ctl;
    logic [IW-1:0] push_idx;

    irq_seq_ctrl #(.NBYTES(CTX_N)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .phase_req (phase_req),
        .irq_pend  (irq_pend),
        .mem_done  (mem_done),
        .ctl       (ctl),
        .push_idx  (push_idx),
        .sp_inc    (sp_inc),
        .ie_clr    (ie_clr),
        .pc_ld     (pc_ld),
        .phase_clr (phase_clr),
        .fetch_set (fetch_set),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    irq_seq_dp #(.DW(DW), .NW(NW), .NBYTES(CTX_N)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .push_idx  (push_idx),
        .sp_cur    (sp_cur),
        .pc_cur    (pc_cur),
        .psw_cur   (psw_cur),
        .irq_num   (irq_num),
        .vec_base  (vec_base),
        .mem_rdata (mem_rdata),
        .mem_done  (mem_done),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_nxt    (pc_nxt)
    );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          mem_done,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          sp_inc,
    input logic          ie_clr,
    input logic          pc_ld,
    input logic          phase_clr,
    input logic          fetch_set
);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_done) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_done) |=> (mem_rd && $stable(mem_addr)));

    // R10
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8
    load_then_fin_chk: assert property (@(posedge clk) disable iff (rst)
        pc_ld |=> (phase_clr && fetch_set));

    // R2
    fin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_set |=> (!fetch_set && !mem_rd && !mem_wr));

    // R3
    sp_single_chk: assert property (@(posedge clk) disable iff (rst)
        sp_inc |=> (!sp_inc && mem_wr));

    // R5
    ie_once_chk: assert property (@(posedge clk) disable iff (rst)
        ie_clr |=> (!ie_clr && !mem_wr));

endmodule

bind irq_entry_seq irq_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_done  (mem_done),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_inc    (sp_inc),
    .ie_clr    (ie_clr),
    .pc_ld     (pc_ld),
    .phase_clr (phase_clr),
    .fetch_set (fetch_set)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

    localparam int IE_POS = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        phase_r;
    logic        phase_clr, fetch_set;
    logic        irq_pend;
    logic [7:0]  irq_num;
    logic [15:0] vec_base;
    logic [15:0] sp_r, pc_r, psw_r;
    logic        sp_inc, pc_ld, ie_clr;
    logic [15:0] pc_nxt, mem_addr;
    logic        mem_rd, mem_wr, mem_done;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  mem [0:4095];
    int          wcnt;
    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [23:0] wq[$];
    int          wr_seen;

    always #4 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .phase_req(phase_r), .phase_clr(phase_clr),
        .fetch_set(fetch_set), .irq_pend(irq_pend), .irq_num(irq_num),
        .vec_base(vec_base), .sp_cur(sp_r), .sp_inc(sp_inc), .pc_cur(pc_r),
        .pc_ld(pc_ld), .pc_nxt(pc_nxt), .psw_cur(psw_r), .ie_clr(ie_clr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    // register models updated by the strobes
    always @(posedge clk) begin
        if (sp_inc) sp_r <= sp_r + 16'd1;
        if (pc_ld) pc_r <= pc_nxt;
        if (ie_clr) psw_r[IE_POS] <= 1'b0;
        if (phase_clr) phase_r <= 1'b0;
        cyc <= cyc + 1;
    end

    // memory with random wait states
    always @(posedge clk) begin
        mem_done <= 1'b0;
        if (!rst && (mem_rd || mem_wr) && !mem_done) begin
            if (wcnt == 0) begin
                mem_done  <= 1'b1;
                mem_rdata <= mem[mem_addr[11:0]];
                if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
                wcnt <= $urandom_range(0, 3);
            end else begin
                wcnt <= wcnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each completed write pops one expected byte (R3, R4)
    always @(negedge clk) begin
        if (!rst && mem_wr && mem_done) begin
            wr_seen++;
            if (wq.size() == 0) begin
                check(1'b0, "R4 extra write", int'({mem_addr, mem_wdata}), 0);
            end else begin
                logic [23:0] e;
                e = wq.pop_front();
                check({mem_addr, mem_wdata} == e, "R3/R4 push byte",
                      int'({mem_addr, mem_wdata}), int'(e));
            end
        end
    end

    // driver: sets up one phase, queues the expected pushes, then follows it
    task automatic run_case(input logic [15:0] sp0, input logic [15:0] pc0,
                            input logic [15:0] psw0, input bit pend,
                            input logic [7:0] num0, input bit swap,
                            input logic [7:0] num1, input logic [15:0] base,
                            input logic [15:0] handler);
        logic [7:0]  num_used;
        logic [15:0] va;
        logic [15:0] rd_a [2];
        int          n_rd, n_ie, cycles, ld_cyc, fin_cyc;
        bit          any_acc;
        @(negedge clk);
        sp_r = sp0; pc_r = pc0; psw_r = psw0;
        irq_pend = pend; irq_num = num0; vec_base = base;
        num_used = swap ? num1 : num0;
        va = base + {7'd0, num_used, 1'b0};
        mem[va[11:0]] = handler[15:8];
        mem[(va + 16'd1) & 16'h0FFF] = handler[7:0];
        wr_seen = 0;
        if (pend) begin
            wq.push_back({sp0,          pc0[15:8]});
            wq.push_back({sp0 + 16'd1,  pc0[7:0]});
            wq.push_back({sp0 + 16'd2,  psw0[15:8]});
            wq.push_back({sp0 + 16'd3,  psw0[7:0]});
        end
        phase_r = 1'b1;
        n_rd = 0; n_ie = 0; cycles = 0; ld_cyc = -1; fin_cyc = -1; any_acc = 0;
        while (fin_cyc < 0 && cycles < 200) begin
            @(negedge clk);
            cycles++;
            if (mem_rd || mem_wr) any_acc = 1;
            if (swap && wr_seen == 1) irq_num = num1;   // before the sampling point (R7)
            if (mem_rd && mem_done && n_rd < 2) begin
                rd_a[n_rd] = mem_addr;
                n_rd++;
                irq_num = ~num1;                         // after the sampling point (R7)
            end
            if (ie_clr) begin
                n_ie++;
                // R5: enable cleared only once all four writes are done
                check(wr_seen == 4 && wq.size() == 0, "R5 ie_clr after pushes", wr_seen, 4);
            end
            if (pc_ld) ld_cyc = cycles;
            if (fetch_set) fin_cyc = cycles;
        end
        @(negedge clk);
        if (!pend) begin
            check(fin_cyc == 2, "R2 bypass latency", fin_cyc, 2);
            check(!any_acc, "R2 no memory access", int'(any_acc), 0);
            check(sp_r == sp0, "R2 SP unchanged", sp_r, sp0);
            check(pc_r == pc0, "R2 PC unchanged", pc_r, pc0);
        end else begin
            check(wq.size() == 0 && wr_seen == 4, "R4 four pushes", wr_seen, 4);
            check(sp_r == sp0 + 16'd4, "R4 final SP", sp_r, sp0 + 16'd4);
            check(n_ie == 1, "R5 single ie_clr", n_ie, 1);
            check(psw_r[IE_POS] == 1'b0, "R5 IE cleared", psw_r[IE_POS], 0);
            check(n_rd == 2 && rd_a[0] == va, "R6/R7 high byte address", rd_a[0], va);
            check(n_rd == 2 && rd_a[1] == va + 16'd1, "R6 low byte address", rd_a[1], va + 16'd1);
            check(pc_r == handler, "R8 new PC", pc_r, handler);
            check(fin_cyc == ld_cyc + 1, "R8 finish after load", fin_cyc, ld_cyc + 1);
        end
        check(phase_r == 1'b0, "R2/R8 phase cleared", phase_r, 0);
        wq.delete();
    endtask

    initial begin
        rst = 1'b1; phase_r = 1'b0; irq_pend = 1'b0; irq_num = '0;
        vec_base = '0; sp_r = '0; pc_r = '0; psw_r = '0; wcnt = 0; wr_seen = 0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        check(!mem_rd && !mem_wr && !sp_inc && !pc_ld && !ie_clr && !phase_clr && !fetch_set,
              "R1 reset outputs", {mem_rd, mem_wr, sp_inc, pc_ld, ie_clr, phase_clr, fetch_set}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_rd && !mem_wr && !fetch_set, "R1 idle after reset",
              {mem_rd, mem_wr, fetch_set}, 0);

        run_case(16'h0200, 16'h1234, 16'h00A5, 1'b0, 8'd3, 1'b0, 8'd0, 16'h0800, 16'h0000);
        run_case(16'h0200, 16'h1234, 16'h5A85, 1'b1, 8'd3, 1'b0, 8'd0, 16'h0800, 16'hBEEF);
        run_case(16'h03FE, 16'hC0DE, 16'hFFFF, 1'b1, 8'd0, 1'b0, 8'd0, 16'h0900, 16'h4321);
        // R7: number changes during the pushes; the value after the last push counts
        run_case(16'h0300, 16'h0F0F, 16'h0180, 1'b1, 8'd5, 1'b1, 8'd9, 16'h0A00, 16'h7E81);
        // R6: table base near the top wraps around zero
        run_case(16'h0400, 16'hAAAA, 16'h8080, 1'b1, 8'd9, 1'b0, 8'd0, 16'hFFF0, 16'h1357);
        run_case(16'h0500, 16'h2468, 16'h0000, 1'b0, 8'd1, 1'b0, 8'd0, 16'h0800, 16'h0000);
        for (int k = 0; k < 6; k++)
            run_case(16'h0600 + 16'(k * 8), 16'($urandom), 16'($urandom) | 16'h0080, 1'b1,
                     8'(k * 7), 1'b0, 8'd0, 16'h0B00, 16'($urandom));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule